// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous request port and an external asynchronous static RAM of 8K by 8 bits. A client presents an address, a direction and, for a write, a data byte, using a valid/ready handshake. The block then runs the RAM's strobes in a fixed order of phases, each a parameterised number of system clock cycles. Read data comes back through a registered byte and a one-cycle done pulse.

The RAM has two chip selects of opposite polarity, and it is selected only when both are active. Writes run under write-enable control. Output enable stays high for the whole write, so the plain minimum write pulse is enough. The controller drives the data pins only while write enable is low. Address and write data are latched once, at acceptance, so they change only while every strobe is idle. If a cycle needs more clocks than its phases use, the remaining clocks are spent in a pad phase with both selects inactive, and the next request is held off until the minimum read or write cycle time has passed.

Top module: `sram_ctrl`

## Requirements
- R1: While rst_ni is low and in the cycle after it rises, sram_cs_n_o=1, sram_cs_o=0, sram_we_n_o=1, sram_oe_n_o=1, sram_dq_oe_o=0, rsp_valid_o=0 and req_ready_o=1.
- R2: sram_we_n_o is low only while sram_cs_n_o=0, sram_cs_o=1 and sram_oe_n_o=1. sram_dq_oe_o=1 exactly in those cycles, and sram_dq_o then carries the accepted write byte.
- R3: sram_addr_o takes the request address at acceptance and holds it through every cycle in which a select is active. It never changes at a clock edge at which sram_we_n_o is low on either side.
- R4: A write is accepted in cycle 0. It then holds selects active with write enable high for SETUP_CYC cycles, holds write enable low for WPULSE_CYC cycles, and keeps selects active with write enable high and the bus released for WREC_CYC cycles.
- R5: A read is accepted in cycle 0. Selects and sram_oe_n_o=0 are then held for ACCESS_CYC cycles with sram_we_n_o=1. sram_dq_i is sampled at the end of the last of these cycles and shows on rsp_rdata_o, with rsp_valid_o high for exactly the next cycle.
- R6: Whenever sram_oe_n_o is low, sram_dq_oe_o is low in that cycle and in the cycle before.
- R7: A request is taken only on a clock edge with req_valid_i and req_ready_o both high. req_ready_o stays low from then until the cycle ends, and req_valid_i is ignored while it is low.
- R8: req_ready_o returns high in cycle N+1 after acceptance. For a write, N = max(WCYCLE_CYC, SETUP_CYC+WPULSE_CYC+WREC_CYC). For a read, N = max(RCYCLE_CYC, ACCESS_CYC).
- R9: rsp_valid_o pulses once per accepted read and never for a write.
- R10: Cycles of a read or write cycle that lie beyond its strobe phases have both selects inactive, sram_we_n_o=1, sram_oe_n_o=1 and the bus released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller can take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (13) | Request address |
| req_wdata_i | input | DATA_W (8) | Write byte |
| rsp_valid_o | output | 1 | One-cycle read done pulse |
| rsp_rdata_o | output | DATA_W (8) | Captured read byte |
| sram_addr_o | output | ADDR_W (13) | RAM address pins |
| sram_dq_o | output | DATA_W (8) | Outgoing data for the RAM data pins |
| sram_dq_oe_o | output | 1 | Drive enable for the data pins |
| sram_dq_i | input | DATA_W (8) | Incoming data from the RAM data pins |
| sram_cs_n_o | output | 1 | Active-low chip select |
| sram_cs_o | output | 1 | Active-high chip select |
| sram_we_n_o | output | 1 | Active-low write enable |
| sram_oe_n_o | output | 1 | Active-low output enable |

## Verification
The properties assume that SETUP_CYC, WPULSE_CYC, WREC_CYC and ACCESS_CYC are each at least one, and that the RAM returns read data within ACCESS_CYC clocks. The bench keeps to both: it runs the default parameters, and its memory model drives read data half a clock after output enable falls. Requests are raised only at the falling clock edge, and each is dropped or replaced there too. The bench also holds req_valid_i high during busy cycles with a different address and direction, and checks that the cycle in flight continues undisturbed.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_WSTRB = 3'd2,
    ST_WREC  = 3'd3,
    ST_RACC  = 3'd4,
    ST_PAD   = 3'd5
  } sram_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_timer.sv
module sram_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned WPULSE_CYC = 2,
  parameter int unsigned WREC_CYC   = 1,
  parameter int unsigned WCYCLE_CYC = 5,
  parameter int unsigned ACCESS_CYC = 3,
  parameter int unsigned RCYCLE_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output sram_state_e       state_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);

  localparam int unsigned W_BODY  = SETUP_CYC + WPULSE_CYC + WREC_CYC;
  localparam int unsigned W_PAD   = (WCYCLE_CYC > W_BODY) ? WCYCLE_CYC - W_BODY : 0;
  localparam int unsigned R_PAD   = (RCYCLE_CYC > ACCESS_CYC) ? RCYCLE_CYC - ACCESS_CYC : 0;
  localparam int unsigned MAX_LEN = max_u(max_u(max_u(SETUP_CYC, WPULSE_CYC), max_u(WREC_CYC, ACCESS_CYC)),
                                          max_u(max_u(W_PAD, R_PAD), 1));
  localparam int unsigned CW      = $clog2(MAX_LEN + 1);

  sram_state_e   st_q, st_d;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic          zero;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  sram_timer #(.W(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld),
    .load_val_i (ld_val),
    .zero_o     (zero)
  );

  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        ld = 1'b1;
        if (req_we_i) begin
          st_d   = ST_SETUP;
          ld_val = CW'(SETUP_CYC - 1);
        end else begin
          st_d   = ST_RACC;
          ld_val = CW'(ACCESS_CYC - 1);
        end
      end
      ST_SETUP: if (zero) begin
        st_d   = ST_WSTRB;
        ld     = 1'b1;
        ld_val = CW'(WPULSE_CYC - 1);
      end
      ST_WSTRB: if (zero) begin
        st_d   = ST_WREC;
        ld     = 1'b1;
        ld_val = CW'(WREC_CYC - 1);
      end
      ST_WREC: if (zero) begin
        if (W_PAD != 0) begin
          st_d   = ST_PAD;
          ld     = 1'b1;
          ld_val = CW'(W_PAD - 1);
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_RACC: if (zero) begin
        if (R_PAD != 0) begin
          st_d   = ST_PAD;
          ld     = 1'b1;
          ld_val = CW'(R_PAD - 1);
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_PAD: if (zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st_q <= st_d;
      // operands latched only at acceptance; strobes are idle then
      if (st_q == ST_IDLE && req_valid_i) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign state_o     = st_q;
  assign last_o      = zero;
  assign addr_o      = addr_q;
  assign wdata_o     = wdata_q;

  // R8: an accepted request always leaves idle in the next cycle
  p_leave_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

endmodule

// File: rtl/sram_pins.sv
module sram_pins
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned WPULSE_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sram_state_e       state_i,
  input  logic              last_i,
  input  logic              req_ready_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  output logic              sram_cs_n_o,
  output logic              sram_cs_o,
  output logic              sram_we_n_o,
  output logic              sram_oe_n_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);

  logic sel, strobe, rd_en;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  assign sel    = (state_i == ST_SETUP) || (state_i == ST_WSTRB) ||
                  (state_i == ST_WREC)  || (state_i == ST_RACC);
  assign strobe = (state_i == ST_WSTRB);
  assign rd_en  = (state_i == ST_RACC);

  assign sram_addr_o  = addr_i;
  assign sram_dq_o    = wdata_i;
  assign sram_dq_oe_o = strobe;
  assign sram_cs_n_o  = ~sel;
  assign sram_cs_o    = sel;
  assign sram_we_n_o  = ~strobe;
  assign sram_oe_n_o  = ~rd_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en && last_i;
      if (rd_en && last_i) rdata_q <= sram_dq_i;
    end
  end

  assign rsp_valid_o = rvalid_q;
  assign rsp_rdata_o = rdata_q;

  // checker state: length of the current write-enable low run
  logic [15:0] we_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           we_run_q <= '0;
    else if (!sram_we_n_o) we_run_q <= we_run_q + 16'd1;
    else                   we_run_q <= '0;
  end

  p_we_selected_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_n_o |-> (!sram_cs_n_o && sram_cs_o && sram_oe_n_o));

  p_addr_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sram_addr_o) |-> (sram_we_n_o && $past(sram_we_n_o) && $past(sram_cs_n_o)));

  p_wp_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_n_o) |-> (we_run_q == 16'(WPULSE_CYC)));

  p_read_we_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_n_o |-> sram_we_n_o);

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_bus_turn_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_n_o |-> (!sram_dq_oe_o && !$past(sram_dq_oe_o)));

  p_ready_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_i |-> (sram_cs_n_o && !sram_cs_o && sram_we_n_o && sram_oe_n_o && !sram_dq_oe_o));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned WPULSE_CYC = 2,
  parameter int unsigned WREC_CYC   = 1,
  parameter int unsigned WCYCLE_CYC = 5,
  parameter int unsigned ACCESS_CYC = 3,
  parameter int unsigned RCYCLE_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_cs_n_o,
  output logic              sram_cs_o,
  output logic              sram_we_n_o,
  output logic              sram_oe_n_o
);

  sram_state_e       state;
  logic              last;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  sram_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SETUP_CYC(SETUP_CYC), .WPULSE_CYC(WPULSE_CYC), .WREC_CYC(WREC_CYC),
    .WCYCLE_CYC(WCYCLE_CYC), .ACCESS_CYC(ACCESS_CYC), .RCYCLE_CYC(RCYCLE_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_ready_o (req_ready_o),
    .state_o     (state),
    .last_o      (last),
    .addr_o      (addr_q),
    .wdata_o     (wdata_q)
  );

  sram_pins #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WPULSE_CYC(WPULSE_CYC)
  ) u_pins (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .state_i      (state),
    .last_i       (last),
    .req_ready_i  (req_ready_o),
    .addr_i       (addr_q),
    .wdata_i      (wdata_q),
    .sram_dq_i    (sram_dq_i),
    .sram_addr_o  (sram_addr_o),
    .sram_dq_o    (sram_dq_o),
    .sram_dq_oe_o (sram_dq_oe_o),
    .sram_cs_n_o  (sram_cs_n_o),
    .sram_cs_o    (sram_cs_o),
    .sram_we_n_o  (sram_we_n_o),
    .sram_oe_n_o  (sram_oe_n_o),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_rdata_o  (rsp_rdata_o)
  );

endmodule

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;

  localparam int AS  = 1;
  localparam int WP  = 2;
  localparam int WR  = 1;
  localparam int WC  = 5;
  localparam int ACC = 3;
  localparam int RC  = 4;
  localparam int NW  = (WC > AS + WP + WR) ? WC : AS + WP + WR;
  localparam int NR  = (RC > ACC) ? RC : ACC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic [12:0] s_addr;
  logic [7:0] s_dq_o, s_dq_i;
  logic s_dq_oe, s_cs_n, s_cs, s_we_n, s_oe_n;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] mem [int];
  logic [7:0] shadow [int];
  logic [7:0] exp_q [$];

  always #4 clk = ~clk;

  sram_ctrl #(
    .SETUP_CYC(AS), .WPULSE_CYC(WP), .WREC_CYC(WR),
    .WCYCLE_CYC(WC), .ACCESS_CYC(ACC), .RCYCLE_CYC(RC)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .sram_addr_o(s_addr), .sram_dq_o(s_dq_o), .sram_dq_oe_o(s_dq_oe),
    .sram_dq_i(s_dq_i), .sram_cs_n_o(s_cs_n), .sram_cs_o(s_cs),
    .sram_we_n_o(s_we_n), .sram_oe_n_o(s_oe_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] mem_rd(input logic [12:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  // RAM model: read data half a clock after strobes settle, write sampled mid-strobe
  always @(negedge clk) begin
    if (!s_cs_n && s_cs && !s_we_n) mem[int'(s_addr)] = s_dq_o;
    if (!s_cs_n && s_cs && s_we_n && !s_oe_n) s_dq_i <= mem_rd(s_addr);
    else s_dq_i <= 8'h00;
  end

  // monitor: responses and bus turnaround
  logic prev_dq_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R9 unexpected response", {24'h0, rsp_rdata}, 32'h0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(rsp_rdata == e, "R5 read data", {24'h0, rsp_rdata}, {24'h0, e});
        end
      end
      if (!s_oe_n) check(!s_dq_oe && !prev_dq_oe, "R6 bus turnaround",
                         {30'h0, s_dq_oe, prev_dq_oe}, 32'h0);
    end
    prev_dq_oe = s_dq_oe;
  end

  // vector order: cs_n, cs, we_n, oe_n, dq_oe, ready
  task automatic access(input bit we, input logic [12:0] a, input logic [7:0] d, input bit spur);
    int n;
    n = we ? NW : NR;
    while (!req_ready) @(negedge clk);
    if (!we) exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (spur) begin
      req_we = ~we; req_addr = ~a; req_wdata = ~d;
    end else begin
      req_valid = 1'b0;
    end
    for (int k = 1; k <= n; k++) begin
      bit sel, stb, rd;
      string tag;
      logic [5:0] obs, exp;
      if (we) begin
        sel = (k <= AS + WP + WR);
        stb = (k > AS) && (k <= AS + WP);
        rd  = 1'b0;
        tag = !sel ? "R10 write pad" : (stb ? "R2 write strobe" : "R4 write phase");
      end else begin
        sel = (k <= ACC);
        stb = 1'b0;
        rd  = sel;
        tag = sel ? "R5 read access" : "R10 read pad";
      end
      obs = {s_cs_n, s_cs, s_we_n, s_oe_n, s_dq_oe, req_ready};
      exp = {~sel, sel, ~stb, ~rd, stb, 1'b0};
      check(obs == exp, tag, {26'h0, obs}, {26'h0, exp});
      if (spur) check(req_ready == 1'b0, "R7 busy ignores valid", {31'h0, req_ready}, 32'h0);
      if (sel) check(s_addr == a, "R3 address held", {19'h0, s_addr}, {19'h0, a});
      if (stb) check(s_dq_o == d, "R2 write data", {24'h0, s_dq_o}, {24'h0, d});
      if (spur && k == n) req_valid = 1'b0;
      @(negedge clk);
    end
    check(req_ready == 1'b1, "R8 ready after cycle time", {31'h0, req_ready}, 32'h1);
    if (we) shadow[int'(a)] = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({s_cs_n, s_cs, s_we_n, s_oe_n, s_dq_oe, req_ready, rsp_valid} == 7'b1011010,
          "R1 reset in", {25'h0, s_cs_n, s_cs, s_we_n, s_oe_n, s_dq_oe, req_ready, rsp_valid}, 32'h5A);
    rst_n = 1'b1;
    @(negedge clk);
    check({s_cs_n, s_cs, s_we_n, s_oe_n, s_dq_oe, req_ready, rsp_valid} == 7'b1011010,
          "R1 reset out", {25'h0, s_cs_n, s_cs, s_we_n, s_oe_n, s_dq_oe, req_ready, rsp_valid}, 32'h5A);

    access(1'b1, 13'h0000, 8'hA5, 1'b0);
    access(1'b1, 13'h1FFF, 8'hFF, 1'b0);
    access(1'b1, 13'h0AAA, 8'h00, 1'b0);
    access(1'b1, 13'h1555, 8'h5A, 1'b1);   // spurious valid during write
    access(1'b0, 13'h0000, 8'h00, 1'b0);
    access(1'b0, 13'h1FFF, 8'h00, 1'b0);
    access(1'b0, 13'h0AAA, 8'h00, 1'b1);   // spurious valid during read
    access(1'b0, 13'h1555, 8'h00, 1'b0);
    access(1'b0, 13'h0123, 8'h00, 1'b0);   // never written
    access(1'b1, 13'h0AAA, 8'h3C, 1'b0);   // overwrite then read back to back
    access(1'b0, 13'h0AAA, 8'h00, 1'b0);
    access(1'b1, 13'h0001, 8'h81, 1'b0);
    access(1'b0, 13'h0001, 8'h00, 1'b0);
    access(1'b0, 13'h0000, 8'h00, 1'b0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9 every read answered once", exp_q.size(), 32'h0);
    check(mem_rd(13'h1FFF) == 8'hFF && mem_rd(13'h0AAA) == 8'h3C, "R2 memory contents",
          {16'h0, mem_rd(13'h1FFF), mem_rd(13'h0AAA)}, 32'hFF3C);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule